// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block is an eight-pin bidirectional general-purpose I/O port that sits on a small register bus. Software controls each pin through a direction register and an output latch. It reads the pins back through a separate port offset, so a read-modify-write on the latch never picks up pin levels by mistake. Each pad has its own output-enable, output-value and input line. Pin inputs pass through a two-stage synchronizer before any logic sees them.

A per-pin ownership multiplexer lets three alternate functions take pins away from GPIO:

- **External bus.** The high byte of an external address/data bus takes all eight pins when the processor mode uses external memory and the bus-disable input is low.
- **Parallel-slave strobes.** In microcontroller-only mode with the slave enable set, pins 0 to 2 become read-strobe, write-strobe and chip-select inputs for a parallel slave port.
- **Alternate compare output.** In microcontroller-only mode, pin 7 can carry an alternate compare output.

The mode, bus-disable, slave-enable and alternate-pin configuration arrive as plain input signals. There is no streaming interface: the register bus is a single-cycle strobe interface with no back-pressure.

Top module: `gpio_mux_port`

## Requirements
- R1: During and after reset the direction register is 0xFF, the latch is 0x00 and read data is 0x00. In mode 2'b00 (microcontroller-only) with no alternate function active, all pins are undriven.
- R2: In GPIO ownership, direction bit 1 makes pin_oe low for that pin, and direction bit 0 drives the latch bit with pin_oe high. Every pin follows its own bit independently.
- R3: The read data register updates on the clock edge after reg_rd is sampled and holds its value while reg_rd is low. Reading offset 1 returns the latch, and reading offset 2 returns the synchronized pin levels, not the latch.
- R4: Writes to offset 0 load the direction register, and writes to offset 1 or 2 load the latch. Writes to offset 3 change nothing, and reads of offset 3 return 0x00.
- R5: With proc_mode not 2'b00 and bus_off low, every pin has pin_oe equal to ext_ad_oe and pin_out equal to ext_ad_out gated by ext_ad_oe, whatever the registers hold.
- R6: With proc_mode 2'b00 and slave_en high, pins 0 to 2 are undriven whatever the direction register holds. slave_ctl[2:0] (read strobe, write strobe, chip select) then equals the synchronized pins 2:0. Otherwise slave_ctl is 3'b111.
- R7: With proc_mode 2'b00 and alt_pin_cfg low, pin 7 is driven with alt_cc_out.
- R8: Priority is bus, then slave strobes, then the alternate output, then GPIO, resolved per pin. The slave and alternate functions apply only in mode 2'b00. With bus_off high, a non-zero mode falls back to GPIO.
- R9: While reset is asserted, a non-zero mode with bus_off low already gives the pins to the external bus.
- R10: pin_out is 0 on every pin whose pin_oe is 0.
- R11: A pin change is visible in a port read issued two cycles after the change. A read issued one cycle after the change still returns the old level.
- R12: Clearing the latch and then writing 0x03 to the direction register leaves pins 0 and 1 undriven and drives pins 2 to 7 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register offset: 0 direction, 1 latch, 2 port, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| proc_mode | input | 2 | 00 microcontroller-only; other codes use external memory |
| bus_off | input | 1 | High releases the pins from the external bus |
| slave_en | input | 1 | Parallel-slave strobe enable |
| alt_pin_cfg | input | 1 | Low routes the alternate compare output to pin 7 |
| ext_ad_out | input | 8 | External bus high-byte output value |
| ext_ad_oe | input | 1 | External bus drive enable |
| alt_cc_out | input | 1 | Alternate compare output value |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| slave_ctl | output | 3 | Synchronized slave strobes {cs, wr, rd}, idle 3'b111 |

## Verification
The ownership function is driven through a table of control settings. These cover:

- plain GPIO with mixed direction patterns;
- slave strobes alone and together with the alternate output;
- the alternate output alone;
- the bus in each non-zero mode, with drive on and off;
- bus-disable in a non-zero mode with every other override requested.

Each row separates one priority level from the one beneath it, because the expected pin pattern differs whenever the wrong owner wins. Directed cases follow the table:

- **Latch versus port reads** use pin levels chosen to differ from the latch, which exposes a read that returns the wrong source.
- **Timed port reads** after a pin change pin the synchronizer depth to exactly two stages.
- **The unused offset** is written and read back to show it changes nothing.
- **Ownership during reset** is checked with the bus mode selected.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    MODE_MCU      = 2'b00,
    MODE_MPU      = 2'b01,
    MODE_EXT      = 2'b10,
    MODE_MPU_BOOT = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OWN_GPIO  = 2'd0,
    OWN_SLAVE = 2'd1,
    OWN_ALT   = 2'd2,
    OWN_BUS   = 2'd3
  } own_e;

  localparam logic [1:0] OFS_DIR  = 2'd0;
  localparam logic [1:0] OFS_LAT  = 2'd1;
  localparam logic [1:0] OFS_PIN  = 2'd2;
  localparam logic [1:0] OFS_HOLE = 2'd3;

  localparam int SLV_PINS = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q
);

  localparam logic [W-1:0] DIR_RST = {W{1'b1}};
  localparam logic [W-1:0] LAT_RST = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
      lat_q <= LAT_RST;
    end else if (wr) begin
      case (addr)
        OFS_DIR:          dir_q <= wdata;
        OFS_LAT, OFS_PIN: lat_q <= wdata;
        default:          ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        OFS_DIR: rdata <= dir_q;
        OFS_LAT: rdata <= lat_q;
        OFS_PIN: rdata <= pin_sync;
        default: rdata <= '0;
      endcase
    end
  end

  // R4
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_DIR) |=> (dir_q == $past(wdata)));

  // R4
  hole_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_HOLE) |=> ($stable(dir_q) && $stable(lat_q)));

  // R3
  lat_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFS_LAT) |=> (rdata == $past(lat_q)));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/gpio_owner_mux.sv
module gpio_owner_mux
  import gpio_mux_pkg::*;
#(
  parameter int W       = 8,
  parameter int ALT_IDX = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_e        mode,
  input  logic         bus_off,
  input  logic         slave_en,
  input  logic         alt_pin_cfg,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] bus_out,
  input  logic         bus_oe,
  input  logic         alt_out,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [SLV_PINS-1:0] slave_ctl
);

  logic bus_act, slv_act, alt_act;

  assign bus_act = (mode != MODE_MCU) && !bus_off;
  assign slv_act = (mode == MODE_MCU) && slave_en;
  assign alt_act = (mode == MODE_MCU) && !alt_pin_cfg;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam bit IS_SLV = (i < SLV_PINS);
    localparam bit IS_ALT = (i == ALT_IDX);
    own_e own;
    logic oe_b, out_b;

    always_comb begin
      if (bus_act)                own = OWN_BUS;
      else if (IS_SLV && slv_act) own = OWN_SLAVE;
      else if (IS_ALT && alt_act) own = OWN_ALT;
      else                        own = OWN_GPIO;
    end

    always_comb begin
      case (own)
        OWN_BUS: begin
          oe_b  = bus_oe;
          out_b = bus_out[i] & bus_oe;
        end
        OWN_SLAVE: begin
          oe_b  = 1'b0;
          out_b = 1'b0;
        end
        OWN_ALT: begin
          oe_b  = 1'b1;
          out_b = alt_out;
        end
        default: begin
          oe_b  = ~dir_q[i];
          out_b = lat_q[i] & ~dir_q[i];
        end
      endcase
    end

    assign pin_oe[i]  = oe_b;
    assign pin_out[i] = out_b;
  end

  assign slave_ctl = slv_act ? pin_sync[SLV_PINS-1:0] : {SLV_PINS{1'b1}};

  // R5
  bus_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != MODE_MCU) && !bus_off) |-> (pin_oe == {W{bus_oe}}));

  // R6
  slave_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_MCU) && slave_en) |-> (pin_oe[SLV_PINS-1:0] == '0));

  // R7
  alt_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_MCU) && !alt_pin_cfg) |-> (pin_oe[ALT_IDX] && pin_out[ALT_IDX] == alt_out));

  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  // R6
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((mode == MODE_MCU) && slave_en) |-> (slave_ctl == {SLV_PINS{1'b1}}));

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [1:0]   proc_mode,
  input  logic         bus_off,
  input  logic         slave_en,
  input  logic         alt_pin_cfg,
  input  logic [W-1:0] ext_ad_out,
  input  logic         ext_ad_oe,
  input  logic         alt_cc_out,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [SLV_PINS-1:0] slave_ctl
);

  localparam int ALT_IDX = W - 1;

  mode_e        mode;
  logic [W-1:0] pin_sync;
  logic [W-1:0] dir_q;
  logic [W-1:0] lat_q;

  assign mode = mode_e'(proc_mode);

  gpio_sync #(.W(W), .STAGES(SYNC_STGS)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_regs #(.W(W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .wdata    (reg_wdata),
    .pin_sync (pin_sync),
    .rdata    (reg_rdata),
    .dir_q    (dir_q),
    .lat_q    (lat_q)
  );

  gpio_owner_mux #(.W(W), .ALT_IDX(ALT_IDX)) i_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .bus_off     (bus_off),
    .slave_en    (slave_en),
    .alt_pin_cfg (alt_pin_cfg),
    .dir_q       (dir_q),
    .lat_q       (lat_q),
    .bus_out     (ext_ad_out),
    .bus_oe      (ext_ad_oe),
    .alt_out     (alt_cc_out),
    .pin_sync    (pin_sync),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .slave_ctl   (slave_ctl)
  );

endmodule

// File: tb/test_gpio_mux_port.sv
`timescale 1ns/1ps
module test_gpio_mux_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] proc_mode = 2'b01;
  logic       bus_off = 1'b0;
  logic       slave_en = 1'b0;
  logic       alt_pin_cfg = 1'b1;
  logic [7:0] ext_ad_out = 8'h5A;
  logic       ext_ad_oe = 1'b1;
  logic       alt_cc_out = 1'b0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [2:0] slave_ctl;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mux_port i_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .proc_mode(proc_mode), .bus_off(bus_off), .slave_en(slave_en),
    .alt_pin_cfg(alt_pin_cfg), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe),
    .alt_cc_out(alt_cc_out), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .slave_ctl(slave_ctl)
  );

  // {ctrl, dir, lat, ext_out, exp_oe, exp_out}
  // ctrl: [7:6] mode, [5] bus_off, [4] slave_en, [3] alt_pin_cfg, [2] ext_oe, [1] alt_out
  localparam int NVEC = 10;
  localparam logic [47:0] VEC [NVEC] = '{
    48'h08_03_00_00_FC_00,  // R12 init sequence
    48'h08_0F_A5_00_F0_A0,  // R2 mixed directions
    48'h18_00_FF_00_F8_F8,  // R6 strobes over outputs
    48'h02_00_00_00_FF_80,  // R7 alternate output
    48'h10_FF_FF_00_80_00,  // R8 strobes and alternate together
    48'h44_00_FF_3C_FF_3C,  // R5 bus drives
    48'h80_00_FF_3C_00_00,  // R5 bus released drive, R10
    48'h72_55_FF_00_AA_AA,  // R8 bus_off gives GPIO, no MCU overrides
    48'hD4_00_FF_81_FF_81,  // R8 bus beats slave request
    48'h0C_F0_0F_FF_0F_0F   // R8 bus ignored in MCU mode
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R9 oe in reset", pin_oe, 8'hFF);
    chk("R9 out in reset", pin_out, 8'h5A);
    proc_mode = 2'b00;
    ext_ad_oe = 1'b0;
    #1;
    chk("R1 oe in reset", pin_oe, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd(2'd0, d); chk("R1 dir", d, 8'hFF);
    rd(2'd1, d); chk("R1 lat", d, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c;
      c = VEC[i][47:40];
      proc_mode = c[7:6]; bus_off = c[5]; slave_en = c[4];
      alt_pin_cfg = c[3]; ext_ad_oe = c[2]; alt_cc_out = c[1];
      ext_ad_out = VEC[i][23:16];
      wr(2'd1, 8'h00);
      wr(2'd0, VEC[i][39:32]);
      wr(2'd1, VEC[i][31:24]);
      chk($sformatf("R2/R5-R8/R10/R12 oe vec %0d", i), pin_oe, VEC[i][15:8]);
      chk($sformatf("R2/R5-R8/R10/R12 out vec %0d", i), pin_out, VEC[i][7:0]);
    end

    // back to plain GPIO
    proc_mode = 2'b00; bus_off = 1'b0; slave_en = 1'b0;
    alt_pin_cfg = 1'b1; ext_ad_oe = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0F);
    pin_in = 8'hF0;
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R3 latch read", d, 8'h0F);
    rd(2'd2, d); chk("R3 port read", d, 8'hF0);
    repeat (2) @(negedge clk);
    chk("R3 rdata hold", reg_rdata, 8'hF0);

    // R4 offset 2 write and unused offset
    wr(2'd2, 8'h3C);
    rd(2'd1, d); chk("R4 port-offset write", d, 8'h3C);
    wr(2'd3, 8'hA5);
    rd(2'd0, d); chk("R4 hole keeps dir", d, 8'h00);
    rd(2'd1, d); chk("R4 hole keeps lat", d, 8'h3C);
    chk("R4 hole keeps pins", pin_out, 8'h3C);
    rd(2'd3, d); chk("R4 hole reads zero", d, 8'h00);

    // R11 synchronizer latency
    pin_in = 8'h66;
    @(negedge clk);
    rd(2'd2, d); chk("R11 one cycle old", d, 8'hF0);
    rd(2'd2, d); chk("R11 two cycles new", d, 8'h66);

    // R6 strobes
    slave_en = 1'b1;
    pin_in = 8'h05;
    repeat (3) @(negedge clk);
    chk("R6 strobes follow pins", {5'b0, slave_ctl}, 8'h05);
    slave_en = 1'b0;
    #1;
    chk("R6 strobes idle", {5'b0, slave_ctl}, 8'h07);

    finish_run();
  end

endmodule